// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a slow timebase strobe (one pulse per cycle of a 32768 Hz reference, delivered as a one-clock enable on the system clock) into periodic events. A 4-bit rate code sets the event period to a power of two of reference ticks. Code 0 turns the generator off. Codes 1 and 2 are folded onto the slow end of the range and behave like codes 8 and 9. The remaining codes give a period of 2^(code-1) ticks.

A free-running 15-bit tick counter runs from reset. An event fires when that counter lands on a multiple of the current period, so events stay on a fixed grid whatever the moment the code was written. Each event pulses a flag-set strobe. The interrupt strobe follows it only when the periodic interrupt enable is set, and the square-wave pulse follows only when the square-wave enable is set. The square-wave output is a one-clock pulse per event, not a 50% wave. If both enables are clear, nothing fires.

Top module: `periodic_irq_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, flag_set_o, irq_o and sqw_pulse_o are low and the tick counter is zero. The first event therefore comes after exactly one period of ticks.
- R2: With rate code 0, no event occurs, whatever the enables.
- R3: With per_irq_en_i and sqw_en_i both low, no event occurs for any rate code.
- R4: For rate codes 3 to 15, events are spaced 2^(code-1) ticks apart: 4 ticks for code 3 up to 16384 ticks for code 15.
- R5: Rate code 1 gives a 128-tick spacing and rate code 2 gives a 256-tick spacing, which are the spacings of codes 8 and 9.
- R6: An event fires on the tick that brings the count of ticks since reset (modulo 32768) to a multiple of the period. Its strobes are high for exactly the one clock after that tick's clock edge. Ticks may arrive on every clock or with gaps.
- R7: Every event raises flag_set_o. irq_o is raised with it only when per_irq_en_i was high on that tick.
- R8: sqw_pulse_o is raised for one clock with an event only when sqw_en_i was high on that tick. Events occur when sqw_en_i is the only enable set.
- R9: A change of rate code does not reset the counter. The first event after the change falls on the next multiple of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-clock strobe per 32768 Hz reference cycle |
| rate_code_i | input | 4 | Rate code; 0 is off |
| per_irq_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| flag_set_o | output | 1 | One-clock strobe that sets the periodic flag |
| irq_o | output | 1 | One-clock interrupt request strobe |
| sqw_pulse_o | output | 1 | One-clock square-wave pulse |

## Verification
Every rate code from 1 to 15 is swept with ticks on every clock. The measured spacing between two events is compared with 2^(code-1), which separates the two aliased codes from the linear ones. The measured event positions are compared with multiples of the period, which separates grid alignment from alignment to the moment of the write. A tick stream with gaps checks that the block counts ticks and not clocks. Sweeps with code 0 and with both enables clear check that the generator is gated off. Runs with only one enable set show which strobe each enable controls. A mid-run code change checks that the next event lands on the new period's grid. A cycle-level reference model, computed by modulo arithmetic on the bench's own tick count, is compared with all three outputs on every clock.

// File: rtl/periodic_irq_pkg.sv
package periodic_irq_pkg;

   // one event, as seen at the block's edge
   typedef struct packed {
      logic flag;
      logic irq;
      logic sqw;
   } pig_event_t;

   // exponent of the period in ticks for a nonzero rate code
   function automatic int unsigned pig_exponent(input int unsigned code,
                                                input int unsigned alias_max,
                                                input int unsigned alias_add);
      if (code <= alias_max) return code + alias_add - 1;
      return code - 1;
   endfunction

endpackage

// File: rtl/pig_tick_counter.sv
module pig_tick_counter #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_q_o,
   output logic [CNT_W-1:0] cnt_next_o
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_next_o = cnt_q + 1'b1;
   assign cnt_q_o    = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_next_o;
   end

   // counter moves by exactly one on a tick and holds otherwise (R6)
   assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (cnt_q == ($past(tick_i) ? $past(cnt_q) + 1'b1 : $past(cnt_q))));
endmodule

// File: rtl/pig_rate_decoder.sv
module pig_rate_decoder
   import periodic_irq_pkg::*;
#(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned CNT_W     = 15,
   parameter int unsigned ALIAS_MAX = 2,
   parameter int unsigned ALIAS_ADD = 7
) (
   input  logic [CODE_W-1:0] code_i,
   output logic              active_o,
   output logic [CNT_W-1:0]  mask_o
);
   localparam int unsigned EXP_W   = CODE_W + 1;
   localparam int unsigned MAX_EXP = (2 ** CODE_W) - 2;

   if (MAX_EXP >= CNT_W) begin : g_bad_cnt_w
      $error("counter too narrow for the largest period");
   end
   if (ALIAS_MAX + ALIAS_ADD - 1 >= CNT_W) begin : g_bad_alias
      $error("aliased codes exceed counter width");
   end

   logic [EXP_W-1:0] exp_w;

   assign active_o = |code_i;

   always_comb begin
      if (code_i <= CODE_W'(ALIAS_MAX))
         exp_w = EXP_W'(code_i) + EXP_W'(ALIAS_ADD) - 1'b1;
      else
         exp_w = EXP_W'(code_i) - 1'b1;
   end

   // low-bit mask of the period: bit i is set when i < exponent
   for (genvar i = 0; i < int'(CNT_W); i++) begin : g_mask
      assign mask_o[i] = active_o && (int'(exp_w) > i);
   end
endmodule

// File: rtl/pig_event_stage.sv
module pig_event_stage
   import periodic_irq_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       active_i,
   input  logic       boundary_i,
   input  logic       pie_i,
   input  logic       sqw_i,
   output pig_event_t ev_o
);
   pig_event_t ev_d;
   logic       fire;

   assign fire    = tick_i && active_i && boundary_i && (pie_i || sqw_i);
   assign ev_d.flag = fire;
   assign ev_d.irq  = fire && pie_i;
   assign ev_d.sqw  = fire && sqw_i;

   if (OUT_REG) begin : g_reg
      pig_event_t ev_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) ev_q <= '0;
         else         ev_q <= ev_d;
      end
      assign ev_o = ev_q;

      assert_irq_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ev_q.irq |-> $past(pie_i));
      assert_sqw_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ev_q.sqw |-> $past(sqw_i));
      assert_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ev_q.flag |-> $past(tick_i));
   end else begin : g_comb
      assign ev_o = ev_d;
   end

   assert_irq_has_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_o.irq |-> ev_o.flag);
   assert_sqw_has_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_o.sqw |-> ev_o.flag);
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
   import periodic_irq_pkg::*;
#(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned CNT_W     = 15,
   parameter int unsigned ALIAS_MAX = 2,
   parameter int unsigned ALIAS_ADD = 7,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        tick_i,
   input  logic [3:0]  rate_code_i,
   input  logic        per_irq_en_i,
   input  logic        sqw_en_i,
   output logic        flag_set_o,
   output logic        irq_o,
   output logic        sqw_pulse_o
);
   if (CODE_W != 4) begin : g_bad_code_w
      $error("rate code port is 4 bits wide");
   end

   logic [CNT_W-1:0] cnt_q, cnt_next, mask;
   logic             active, boundary;
   pig_event_t       ev;

   pig_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cnt_q_o    (cnt_q),
      .cnt_next_o (cnt_next)
   );

   pig_rate_decoder #(
      .CODE_W(CODE_W), .CNT_W(CNT_W),
      .ALIAS_MAX(ALIAS_MAX), .ALIAS_ADD(ALIAS_ADD)
   ) u_dec (
      .code_i   (rate_code_i[CODE_W-1:0]),
      .active_o (active),
      .mask_o   (mask)
   );

   // next count lands on a multiple of the period
   assign boundary = ((cnt_next & mask) == '0);

   pig_event_stage #(.OUT_REG(OUT_REG)) u_ev (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .active_i   (active),
      .boundary_i (boundary),
      .pie_i      (per_irq_en_i),
      .sqw_i      (sqw_en_i),
      .ev_o       (ev)
   );

   assign flag_set_o  = ev.flag;
   assign irq_o       = ev.irq;
   assign sqw_pulse_o = ev.sqw;

   if (OUT_REG) begin : g_chk
      assert_code_zero_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         flag_set_o |-> $past(rate_code_i != 4'd0));
      assert_gated_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         flag_set_o |-> $past(per_irq_en_i || sqw_en_i));
      assert_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         flag_set_o |-> ((cnt_q & $past(mask)) == '0));
      assert_single_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         flag_set_o |=> !flag_set_o);
   end
endmodule

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n, tick, pie_en, sqw_en;
   logic [3:0] rate_code;
   logic       flag_set, irq, sqw_pulse;

   always #2 clk = ~clk;

   periodic_irq_gen dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_code_i(rate_code),
      .per_irq_en_i(pie_en), .sqw_en_i(sqw_en),
      .flag_set_o(flag_set), .irq_o(irq), .sqw_pulse_o(sqw_pulse)
   );

   int checks = 0, failures = 0, mism = 0;
   int tick_total = 0;
   logic exp_pf = 0, exp_irq = 0, exp_sqw = 0;
   int ev_cnt, irq_cnt, sqw_cnt, first_evt, last_evt, prev_evt;
   bit done = 0;

   function automatic int period_of(input int c);
      int e;
      e = (c <= 2) ? c + 7 : c;
      return 1 << (e - 1);
   endfunction

   // reference model from the requirements
   always @(posedge clk) begin
      exp_pf = 0; exp_irq = 0; exp_sqw = 0;
      if (!rst_n) tick_total = 0;
      else if (tick) begin
         tick_total = tick_total + 1;
         if (rate_code != 0 && (pie_en || sqw_en) &&
             (tick_total % period_of(int'(rate_code))) == 0) begin
            exp_pf = 1; exp_irq = pie_en; exp_sqw = sqw_en;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (flag_set !== exp_pf || irq !== exp_irq || sqw_pulse !== exp_sqw) mism++;
         if (flag_set) begin
            ev_cnt++;
            prev_evt = last_evt;
            last_evt = tick_total;
            if (first_evt < 0) first_evt = tick_total;
         end
         if (irq) irq_cnt++;
         if (sqw_pulse) sqw_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic clear_log();
      ev_cnt = 0; irq_cnt = 0; sqw_cnt = 0;
      first_evt = -1; last_evt = -1; prev_evt = -1;
   endtask

   task automatic run_ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(posedge clk); #1;
         tick = 1'b0;
         for (int j = 1; j < gap; j++) begin @(posedge clk); #1; end
      end
   endtask

   task automatic settle();
      repeat (2) begin @(posedge clk); #1; end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int p, t0, expf;
      rst_n = 0; tick = 0; pie_en = 0; sqw_en = 0; rate_code = 0;
      clear_log();
      repeat (3) begin @(posedge clk); #1; end
      // R1: outputs low during reset
      check(!flag_set && !irq && !sqw_pulse, "R1 reset outputs", int'(flag_set), 0);
      rst_n = 1;
      @(posedge clk); #1;
      check(!flag_set && !irq && !sqw_pulse, "R1 after release", int'(flag_set), 0);

      // R1/R6: first event after one period from a zero count
      pie_en = 1; rate_code = 4'd3;
      run_ticks(4, 1); settle();
      check(first_evt == 4, "R1 first event at count 4", first_evt, 4);

      // R4/R5/R6/R7/R8: sweep of every nonzero code, interrupt only
      for (int c = 1; c < 16; c++) begin
         p = period_of(c);
         rate_code = 4'(c); clear_log();
         run_ticks(2 * p + 2, 1); settle();
         if (c <= 2)
            check(last_evt - prev_evt == p, "R5 aliased spacing", last_evt - prev_evt, p);
         else
            check(last_evt - prev_evt == p, "R4 spacing", last_evt - prev_evt, p);
         check(last_evt % p == 0, "R6 aligned to period grid", last_evt % p, 0);
         check(irq_cnt == ev_cnt && ev_cnt >= 2, "R7 irq with every event", irq_cnt, ev_cnt);
         check(sqw_cnt == 0, "R8 no sqw when disabled", sqw_cnt, 0);
      end

      // R2: code 0 is off with both enables set
      pie_en = 1; sqw_en = 1; rate_code = 4'd0; clear_log();
      run_ticks(300, 1); settle();
      check(ev_cnt == 0, "R2 code 0 no events", ev_cnt, 0);

      // R3: both enables clear, every code
      pie_en = 0; sqw_en = 0;
      for (int c = 0; c < 16; c++) begin
         rate_code = 4'(c); clear_log();
         run_ticks(40, 1); settle();
         check(ev_cnt == 0, "R3 both enables clear", ev_cnt, 0);
      end

      // R8/R7: square-wave enable alone
      sqw_en = 1; pie_en = 0; rate_code = 4'd4; clear_log();
      run_ticks(40, 1); settle();
      check(ev_cnt >= 4 && sqw_cnt == ev_cnt, "R8 sqw pulse per event", sqw_cnt, ev_cnt);
      check(irq_cnt == 0, "R7 no irq without enable", irq_cnt, 0);

      // R6: gapped ticks, both enables
      pie_en = 1; sqw_en = 1; rate_code = 4'd3; clear_log();
      run_ticks(20, 3); settle();
      check(last_evt - prev_evt == 4, "R6 gapped tick spacing", last_evt - prev_evt, 4);
      check(irq_cnt == ev_cnt && sqw_cnt == ev_cnt, "R7 R8 both strobes", irq_cnt, ev_cnt);

      // R9: rate change keeps the counter running
      sqw_en = 0; rate_code = 4'd6;
      run_ticks(50, 1); settle();
      t0 = tick_total;
      rate_code = 4'd8; clear_log();
      run_ticks(300, 1); settle();
      expf = (t0 / 128 + 1) * 128;
      check(first_evt == expf, "R9 first event after code change", first_evt, expf);

      check(mism == 0, "R6 cycle model match", mism, 0);
      finish_run();
   end
endmodule